// File: doc/BRIEF.md
# Downstream Port Interrupt Generator

This block sits in each port of a PCIe switch and turns local interrupt events into message requests for the switch core. It holds one sticky status bit for each interrupt source: a hot-plug event and two link-bandwidth change events. Each bit has its own enable. Software clears a bit by writing one to it. The block ORs the enabled status bits into one interrupt condition and watches that condition for changes.

Two configuration bits pick the signalling style. When MSI is enabled, a rising condition yields a single MSI request. When MSI is off and legacy interrupts are allowed, the block drives a virtual INTA wire through assert and deassert message requests. Only INTA is ever used. A register records whether INTA is currently asserted toward the core. The block compares that register with the level the wire ought to have. When the two differ, it issues the message that brings them back into agreement. As a result the wire is never left stuck and the two message types always alternate.

Requests go out on a valid/ready channel. A request that has been presented stays unchanged until the core accepts it. An instance built for the upstream port issues nothing.

Top module: `dsport_irq_gen`

## Requirements
- R1: A one on `evt_set[i]` sets status bit i, and a one on `clr_w1c[i]` clears it. When both arrive on the same cycle the bit ends up set. Bit 0 is hot-plug; bits 1 and 2 are the bandwidth events.
- R2: The interrupt condition is the OR of the status bits whose `src_en` bit is 1. Clearing an enable removes that bit's contribution, exactly as clearing the status bit would.
- R3: When the condition rises while `msi_en` is 1, exactly one request with `req_kind` = 1 (MSI) is issued, whatever the value of `intx_off`.
- R4: When the condition rises while `msi_en` is 0 and `intx_off` is 0, exactly one request with `req_kind` = 2 (assert INTA) is issued. Codes 2 and 3 are the only legacy codes; no other INTx line exists.
- R5: When the condition falls while INTA is asserted, exactly one request with `req_kind` = 3 (deassert INTA) is issued.
- R6: No request is issued when the condition falls with `msi_en` at 1. No request is issued on either edge while `msi_en` is 0 and `intx_off` is 1. A status bit that is already set does not issue a second request when its event arrives again.
- R7: Setting `intx_off` while INTA is asserted issues a deassert request. Clearing it again while the condition is still active issues an assert request.
- R8: A request becomes valid on the clock edge after the edge that captured its event. While `req_rdy` is 0, `req_vld` and `req_kind` hold steady.
- R9: Accepted legacy requests strictly alternate between assert and deassert, and the first one after reset is an assert.
- R10: With parameter `IS_UPSTREAM` = 1, `req_vld` never rises.
- R11: After reset the status bits are zero, no request is pending, and INTA counts as deasserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_set | input | N_SRC | Per-source event pulse that sets status |
| clr_w1c | input | N_SRC | Per-source write-one-to-clear strobe |
| src_en | input | N_SRC | Per-source interrupt enable |
| msi_en | input | 1 | MSI enabled |
| intx_off | input | 1 | Legacy interrupts disabled |
| req_rdy | input | 1 | Switch core accepts the presented request |
| req_vld | output | 1 | Request presented |
| req_kind | output | 2 | 1 = MSI, 2 = assert INTA, 3 = deassert INTA |
| sts | output | N_SRC | Current status bits |

## Verification
The bench sets and clears a status bit on the same cycle. A design that let the clear win would lose the event and send no assert. It masks a still-set source and then unmasks it, which catches a design that ignores enables or needs a fresh event before it asserts again. It toggles the legacy-disable bit while INTA is up; a design without the sent-state register would leave the wire stuck high. With ready held low, it queues an assert and then a deassert. Any design that reorders or drops one of them, or that changes a presented request before the core accepts it, shows up in the order and count of accepted messages.

// File: rtl/irqgen_pkg.sv
package irqgen_pkg;

    localparam int SRC_HOTPLUG = 0;
    localparam int SRC_BW_MGMT = 1;
    localparam int SRC_BW_AUTO = 2;
    localparam int N_SRC_DEF   = 3;

    typedef enum logic [1:0] {
        MSG_NONE     = 2'd0,
        MSG_MSI      = 2'd1,
        MSG_INTA_ON  = 2'd2,
        MSG_INTA_OFF = 2'd3
    } irq_msg_e;

    typedef struct packed {
        logic msi_en;
        logic intx_off;
    } irq_cfg_t;

    typedef struct packed {
        logic rise;
        logic level;
    } cond_evt_t;

    // Level the virtual INTA wire should carry for a given condition and configuration.
    function automatic logic inta_target(input logic level, input irq_cfg_t cfg);
        return level & ~cfg.msi_en & ~cfg.intx_off;
    endfunction

endpackage

// File: rtl/irqgen_status.sv
module irqgen_status #(
    parameter int N_SRC = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] evt_set,
    input  logic [N_SRC-1:0] clr_w1c,
    output logic [N_SRC-1:0] sts
);
    logic [N_SRC-1:0] sts_q;

    for (genvar i = 0; i < N_SRC; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                sts_q[i] <= 1'b0;
            else if (evt_set[i])
                sts_q[i] <= 1'b1;      // set beats a simultaneous clear
            else if (clr_w1c[i])
                sts_q[i] <= 1'b0;
        end
    end

    assign sts = sts_q;

    // R1: an event always leaves its bit set on the following cycle
    p_set_wins_r1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(evt_set) != '0)) |-> ((sts_q & $past(evt_set)) == $past(evt_set)));

endmodule

// File: rtl/irqgen_cond.sv
module irqgen_cond
    import irqgen_pkg::*;
#(
    parameter int N_SRC = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] sts,
    input  logic [N_SRC-1:0] src_en,
    output cond_evt_t        ev
);
    logic cond_now;
    logic cond_q;

    assign cond_now = |(sts & src_en);

    always_ff @(posedge clk) begin
        if (rst) cond_q <= 1'b0;
        else     cond_q <= cond_now;
    end

    assign ev.level = cond_now;
    assign ev.rise  = cond_now & ~cond_q;

endmodule

// File: rtl/irqgen_msg.sv
module irqgen_msg
    import irqgen_pkg::*;
#(
    parameter bit IS_UPSTREAM = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  cond_evt_t ev,
    input  irq_cfg_t  cfg,
    input  logic      req_rdy,
    output logic      req_vld,
    output irq_msg_e  req_kind
);
    localparam logic GEN_EN = !IS_UPSTREAM;

    logic     vld_q;
    irq_msg_e kind_q;
    logic     msi_pend;
    logic     inta_lvl;      // INTA level already committed toward the core
    logic     msi_go;
    logic     want;
    logic     can_load;
    logic     take_msi;
    logic     flip;
    irq_msg_e nxt;

    assign msi_go   = msi_pend | (ev.rise & cfg.msi_en & GEN_EN);
    assign want     = inta_target(ev.level, cfg) & GEN_EN;
    assign can_load = !vld_q || req_rdy;

    always_comb begin
        nxt      = MSG_NONE;
        take_msi = 1'b0;
        flip     = 1'b0;
        if (msi_go) begin
            nxt      = MSG_MSI;
            take_msi = 1'b1;
        end else if (want != inta_lvl) begin
            nxt  = want ? MSG_INTA_ON : MSG_INTA_OFF;
            flip = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q    <= 1'b0;
            kind_q   <= MSG_NONE;
            msi_pend <= 1'b0;
            inta_lvl <= 1'b0;
        end else begin
            msi_pend <= msi_go & ~(can_load & take_msi);
            if (can_load) begin
                vld_q  <= (nxt != MSG_NONE);
                kind_q <= nxt;
                if (flip) inta_lvl <= want;
            end
        end
    end

    assign req_vld  = vld_q;
    assign req_kind = kind_q;

    // Shadow of the wire as seen by the core, advanced only on acceptance.
    logic ax_up;
    always_ff @(posedge clk) begin
        if (rst)
            ax_up <= 1'b0;
        else if (vld_q && req_rdy && kind_q == MSG_INTA_ON)
            ax_up <= 1'b1;
        else if (vld_q && req_rdy && kind_q == MSG_INTA_OFF)
            ax_up <= 1'b0;
    end

    // R8: a presented request is frozen until accepted
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (vld_q && !req_rdy) |=> (vld_q && $stable(kind_q)));

    // R3: a valid request always carries a real message code
    p_kind_legal_r3: assert property (@(posedge clk) disable iff (rst)
        vld_q |-> (kind_q != MSG_NONE));

    // R9: assert only when the core sees the wire low
    p_alt_on_r9: assert property (@(posedge clk) disable iff (rst)
        (vld_q && req_rdy && kind_q == MSG_INTA_ON) |-> !ax_up);

    // R9: deassert only when the core sees the wire high
    p_alt_off_r9: assert property (@(posedge clk) disable iff (rst)
        (vld_q && req_rdy && kind_q == MSG_INTA_OFF) |-> ax_up);

endmodule

// File: rtl/dsport_irq_gen.sv
module dsport_irq_gen
    import irqgen_pkg::*;
#(
    parameter int N_SRC       = N_SRC_DEF,
    parameter bit IS_UPSTREAM = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] evt_set,
    input  logic [N_SRC-1:0] clr_w1c,
    input  logic [N_SRC-1:0] src_en,
    input  logic             msi_en,
    input  logic             intx_off,
    input  logic             req_rdy,
    output logic             req_vld,
    output logic [1:0]       req_kind,
    output logic [N_SRC-1:0] sts
);
    cond_evt_t ev;
    irq_cfg_t  cfg;
    irq_msg_e  kind;

    assign cfg.msi_en   = msi_en;
    assign cfg.intx_off = intx_off;

    irqgen_status #(.N_SRC(N_SRC)) u_status (
        .clk     (clk),
        .rst     (rst),
        .evt_set (evt_set),
        .clr_w1c (clr_w1c),
        .sts     (sts)
    );

    irqgen_cond #(.N_SRC(N_SRC)) u_cond (
        .clk    (clk),
        .rst    (rst),
        .sts    (sts),
        .src_en (src_en),
        .ev     (ev)
    );

    irqgen_msg #(.IS_UPSTREAM(IS_UPSTREAM)) u_msg (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .cfg      (cfg),
        .req_rdy  (req_rdy),
        .req_vld  (req_vld),
        .req_kind (kind)
    );

    assign req_kind = kind;

    // R10: an upstream instance stays silent
    p_up_silent_r10: assert property (@(posedge clk) disable iff (rst)
        IS_UPSTREAM |-> !req_vld);

endmodule

// File: tb/sim_dsport_irq_gen.sv
module sim_dsport_irq_gen;

    localparam int N = 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] evt_set = '0;
    logic [N-1:0] clr_w1c = '0;
    logic [N-1:0] src_en  = '1;
    logic         msi_en   = 1'b0;
    logic         intx_off = 1'b0;
    logic         req_rdy  = 1'b1;
    logic         req_vld, up_vld;
    logic [1:0]   req_kind, up_kind;
    logic [N-1:0] sts, up_sts;

    always #2.5 clk = ~clk;   // 200 MHz

    dsport_irq_gen #(.N_SRC(N), .IS_UPSTREAM(1'b0)) u0 (
        .clk(clk), .rst(rst), .evt_set(evt_set), .clr_w1c(clr_w1c), .src_en(src_en),
        .msi_en(msi_en), .intx_off(intx_off), .req_rdy(req_rdy),
        .req_vld(req_vld), .req_kind(req_kind), .sts(sts));

    dsport_irq_gen #(.N_SRC(N), .IS_UPSTREAM(1'b1)) u1 (
        .clk(clk), .rst(rst), .evt_set(evt_set), .clr_w1c(clr_w1c), .src_en(src_en),
        .msi_en(msi_en), .intx_off(intx_off), .req_rdy(req_rdy),
        .req_vld(up_vld), .req_kind(up_kind), .sts(up_sts));

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Accepted-message monitor (reads ports only)
    int         acc_cnt = 0;
    int         up_cnt  = 0;
    logic [1:0] last_k  = 2'd0;
    logic [1:0] prev_k  = 2'd0;
    always @(posedge clk) begin
        if (!rst && req_vld && req_rdy) begin
            acc_cnt <= acc_cnt + 1;
            prev_k  <= last_k;
            last_k  <= req_kind;
        end
        if (!rst && up_vld) up_cnt <= up_cnt + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic [2:0] evt;
        logic [2:0] clr;
        logic [2:0] en;
        logic       msi;
        logic       dis;
        logic [1:0] cnt;
        logic [1:0] kind;
    } vec_t;

    // kind: 1 MSI, 2 assert INTA, 3 deassert INTA, 0 when cnt is 0
    localparam vec_t VECS [18] = '{
        '{3'b001, 3'b000, 3'b111, 1'b0, 1'b0, 2'd1, 2'd2},  // R4
        '{3'b000, 3'b001, 3'b111, 1'b0, 1'b0, 2'd1, 2'd3},  // R5
        '{3'b010, 3'b000, 3'b111, 1'b1, 1'b0, 2'd1, 2'd1},  // R3
        '{3'b000, 3'b010, 3'b111, 1'b1, 1'b0, 2'd0, 2'd0},  // R6
        '{3'b100, 3'b000, 3'b111, 1'b1, 1'b1, 2'd1, 2'd1},  // R3
        '{3'b000, 3'b100, 3'b111, 1'b1, 1'b1, 2'd0, 2'd0},  // R6
        '{3'b001, 3'b000, 3'b111, 1'b0, 1'b1, 2'd0, 2'd0},  // R6
        '{3'b000, 3'b001, 3'b111, 1'b0, 1'b1, 2'd0, 2'd0},  // R6
        '{3'b010, 3'b000, 3'b111, 1'b0, 1'b0, 2'd1, 2'd2},  // R4
        '{3'b100, 3'b000, 3'b111, 1'b0, 1'b0, 2'd0, 2'd0},  // R6
        '{3'b000, 3'b010, 3'b111, 1'b0, 1'b0, 2'd0, 2'd0},  // R2
        '{3'b000, 3'b000, 3'b011, 1'b0, 1'b0, 2'd1, 2'd3},  // R2
        '{3'b000, 3'b000, 3'b111, 1'b0, 1'b0, 2'd1, 2'd2},  // R2
        '{3'b000, 3'b000, 3'b111, 1'b0, 1'b1, 2'd1, 2'd3},  // R7
        '{3'b000, 3'b000, 3'b111, 1'b0, 1'b0, 2'd1, 2'd2},  // R7
        '{3'b000, 3'b100, 3'b111, 1'b0, 1'b0, 2'd1, 2'd3},  // R5
        '{3'b001, 3'b001, 3'b111, 1'b0, 1'b0, 2'd1, 2'd2},  // R1
        '{3'b000, 3'b001, 3'b111, 1'b0, 1'b0, 2'd1, 2'd3}   // R1
    };

    initial begin
        repeat (1000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R11: reset state
        chk("R11 sts", int'(sts), 0);
        chk("R11 vld", int'(req_vld), 0);

        foreach (VECS[i]) begin
            base = acc_cnt;
            @(negedge clk);
            evt_set = VECS[i].evt;  clr_w1c = VECS[i].clr;  src_en = VECS[i].en;
            msi_en  = VECS[i].msi;  intx_off = VECS[i].dis;
            @(negedge clk);
            evt_set = '0;  clr_w1c = '0;
            repeat (3) @(negedge clk);
            chk($sformatf("vec%0d count R3/R4/R5/R6/R7", i), acc_cnt - base, int'(VECS[i].cnt));
            if (VECS[i].cnt != 0)
                chk($sformatf("vec%0d kind R3/R4/R5/R7", i), int'(last_k), int'(VECS[i].kind));
            if (i == 16) chk("R1 set beats clear", int'(sts[0]), 1);
        end

        // R8: latency and hold while not ready (MSI mode)
        req_rdy = 1'b0;  msi_en = 1'b1;
        evt_set = 3'b010;
        @(negedge clk);                       // captured at this edge
        evt_set = '0;
        chk("R8 not yet valid", int'(req_vld), 0);
        @(negedge clk);
        chk("R8 valid next edge", int'(req_vld), 1);
        chk("R8 kind MSI", int'(req_kind), 1);
        repeat (4) @(negedge clk);
        chk("R8 held valid", int'(req_vld), 1);
        chk("R8 held kind", int'(req_kind), 1);
        base = acc_cnt;
        req_rdy = 1'b1;
        @(negedge clk);
        chk("R8 accepted once", acc_cnt - base, 1);
        chk("R8 drops after accept", int'(req_vld), 0);
        clr_w1c = 3'b010;
        @(negedge clk) clr_w1c = '0;
        repeat (3) @(negedge clk);

        // R9: assert then deassert queued behind a stalled core
        msi_en = 1'b0;  req_rdy = 1'b0;
        base = acc_cnt;
        evt_set = 3'b001;
        @(negedge clk) evt_set = '0;
        @(negedge clk) clr_w1c = 3'b001;
        @(negedge clk) clr_w1c = '0;
        chk("R9 assert held", int'(req_kind), 2);
        req_rdy = 1'b1;
        repeat (4) @(negedge clk);
        chk("R9 two accepted", acc_cnt - base, 2);
        chk("R9 first assert", int'(prev_k), 2);
        chk("R9 then deassert", int'(last_k), 3);

        // R10: upstream copy saw every stimulus above
        chk("R10 upstream silent", up_cnt, 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule